// File: doc/BRIEF.md
# Supply Power-Fail Warning Monitor

This block compares a digitised supply reading, in millivolts, against a software-selected threshold. When the supply is found below that threshold it raises a sticky warning flag, asserts an interrupt if that interrupt is enabled, and tells the non-volatile memory controller to refuse writes until the supply has recovered by a hysteresis margin. The comparison runs every cycle against the most recently accepted reading. So the warning appears on a falling crossing, and also when the monitor is switched on while the supply is already low, and when software raises the threshold above the last reading.

Supply readings arrive on a valid/ready stream. The block accepts a reading in any cycle where `smp_valid` and `smp_ready` are both high. It holds `smp_ready` low whenever the comparator is inactive: while it is disabled, while the fast clock is stopped, and in the deepest sleep state. A producer must hold its reading until it is taken, or drop it, and the last accepted reading stays stored across inactive periods. Software writes a configuration word, the event flag and the interrupt enable through a simple write port.

Top module: `pfw_monitor`

## Requirements
- R1: After reset the event flag, interrupt, write block and `smp_ready` are all low, and readings offered while the comparator is disabled are not accepted.
- R2: In the configuration word, bit 0 enables the comparator and bits 4:1 hold the normal-mode code. Code c from 4 to 15 selects 1700 + (c-4)*100 mV, and codes 0 to 3 select 1700 mV.
- R3: When `hv_mode` is 1, the threshold comes from bits 11:8, and code c selects 2700 + c*100 mV.
- R4: A reading strictly below the active threshold sets the event flag two rising edges after it is offered. A reading equal to the threshold does not set it.
- R5: Enabling the comparator while the last accepted reading is below the threshold sets the event flag without a new reading.
- R6: Rewriting the threshold to a level above the last accepted reading sets the event flag without a new reading.
- R7: Once the below state is entered, it is left only when a reading exceeds threshold + HYST_MV (default 50). A reading equal to that sum keeps the below state.
- R8: `nvm_wr_block` is high exactly while the comparator is active and in the below state.
- R9: With `hfclk_run` low or `sys_off` high, the comparator is inactive: `smp_ready` goes low at once, the below state and write block clear on the next edge, and no event is raised.
- R10: The event flag stays set until software writes 0 to the event register (select 1, bit 0). Writing 1 has no effect. `warn_irq` is the event flag AND the interrupt enable (select 2, bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 event, 2 interrupt enable |
| reg_wdata | input | 12 | Register write data |
| hv_mode | input | 1 | Supply mode: 1 selects the high-voltage threshold field |
| hfclk_run | input | 1 | Fast clock running |
| sys_off | input | 1 | Deepest sleep state active |
| smp_valid | input | 1 | Supply reading valid |
| smp_mv | input | MV_W | Supply reading in millivolts |
| smp_ready | output | 1 | Reading accepted this cycle if valid |
| warn_evt | output | 1 | Sticky power-fail warning flag |
| warn_irq | output | 1 | Warning interrupt |
| nvm_wr_block | output | 1 | Inhibits non-volatile memory writes |

## Verification
A wrong stored reading, a wrong threshold decode or a stuck below state shows up on `nvm_wr_block` and `warn_evt` on the second rising edge after the stimulus, whether that stimulus is a reading or a register write. A wrong active decode shows up on `smp_ready` in the same cycle. The bench crosses each threshold with readings one millivolt on either side of it, and of threshold plus hysteresis, so an off-by-one comparison or a misplaced field flips an output within two cycles.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  localparam int CFG_W    = 12;
  localparam int CODE_W   = 4;
  localparam int EN_BIT   = 0;
  localparam int NRM_LSB  = 1;
  localparam int HV_LSB   = 8;

  typedef enum logic [1:0] {
    SEL_CFG = 2'd0,
    SEL_EVT = 2'd1,
    SEL_IEN = 2'd2
  } pfw_sel_e;

  typedef struct packed {
    logic [CODE_W-1:0] hv_code;
    logic [CODE_W-1:0] nrm_code;
    logic              en;
  } pfw_cfg_t;
endpackage

// File: rtl/pfw_regs.sv
module pfw_regs
  import pfw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [CFG_W-1:0] wdata,
  input  logic             evt_set,
  output pfw_cfg_t         cfg,
  output logic             evt_q,
  output logic             ien_q
);
  logic wr_cfg, wr_evt_clr, wr_ien;

  always_comb begin
    wr_cfg     = we && (sel == SEL_CFG);
    wr_evt_clr = we && (sel == SEL_EVT) && !wdata[0];
    wr_ien     = we && (sel == SEL_IEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      evt_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg.en       <= wdata[EN_BIT];
        cfg.nrm_code <= wdata[NRM_LSB +: CODE_W];
        cfg.hv_code  <= wdata[HV_LSB +: CODE_W];
      end
      if (evt_set)         evt_q <= 1'b1;
      else if (wr_evt_clr) evt_q <= 1'b0;
      if (wr_ien) ien_q <= wdata[0];
    end
  end
endmodule

// File: rtl/pfw_thresh.sv
module pfw_thresh
  import pfw_pkg::*;
#(
  parameter int MV_W       = 13,
  parameter int STEP_MV    = 100,
  parameter int NRM_MIN_MV = 1700,
  parameter int NRM_FLOOR  = 4,
  parameter int HV_MIN_MV  = 2700,
  parameter int HYST_MV    = 50
)(
  input  pfw_cfg_t          cfg,
  input  logic              hv_mode,
  output logic [MV_W-1:0]   thr_mv,
  output logic [MV_W-1:0]   rel_mv
);
  int nrm_i, hv_i;

  always_comb begin
    if (int'(cfg.nrm_code) < NRM_FLOOR) nrm_i = NRM_MIN_MV;
    else nrm_i = NRM_MIN_MV + (int'(cfg.nrm_code) - NRM_FLOOR) * STEP_MV;
    hv_i   = HV_MIN_MV + int'(cfg.hv_code) * STEP_MV;
    thr_mv = hv_mode ? MV_W'(hv_i) : MV_W'(nrm_i);
  end

  generate
    if (HYST_MV == 0) begin : g_nohyst
      assign rel_mv = thr_mv;
    end else begin : g_hyst
      assign rel_mv = thr_mv + MV_W'(HYST_MV);
    end
  endgenerate
endmodule

// File: rtl/pfw_cmp.sv
module pfw_cmp #(
  parameter int MV_W = 13
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            take,
  input  logic [MV_W-1:0] smp_mv,
  input  logic [MV_W-1:0] thr_mv,
  input  logic [MV_W-1:0] rel_mv,
  output logic            low_q,
  output logic            fire
);
  logic [MV_W-1:0] vdd_q;
  logic            seen_q;
  logic            below, recovered, low_nxt;

  always_comb begin
    below     = seen_q && (vdd_q < thr_mv);
    recovered = vdd_q > rel_mv;
    low_nxt   = active && (low_q ? !recovered : below);
    fire      = low_nxt && !low_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vdd_q  <= '0;
      seen_q <= 1'b0;
      low_q  <= 1'b0;
    end else begin
      if (take) begin
        vdd_q  <= smp_mv;
        seen_q <= 1'b1;
      end
      low_q <= low_nxt;
    end
  end
endmodule

// File: rtl/pfw_monitor.sv
module pfw_monitor
  import pfw_pkg::*;
#(
  parameter int MV_W    = 13,
  parameter int HYST_MV = 50
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [11:0]      reg_wdata,
  input  logic             hv_mode,
  input  logic             hfclk_run,
  input  logic             sys_off,
  input  logic             smp_valid,
  input  logic [MV_W-1:0]  smp_mv,
  output logic             smp_ready,
  output logic             warn_evt,
  output logic             warn_irq,
  output logic             nvm_wr_block
);
  pfw_cfg_t        cfg;
  logic            ien;
  logic            active, fire, low_q;
  logic [MV_W-1:0] thr_mv, rel_mv;

  assign active       = cfg.en && hfclk_run && !sys_off;
  assign smp_ready    = active;
  assign nvm_wr_block = low_q;
  assign warn_irq     = warn_evt && ien;

  pfw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .evt_set(fire), .cfg(cfg), .evt_q(warn_evt), .ien_q(ien)
  );

  pfw_thresh #(.MV_W(MV_W), .HYST_MV(HYST_MV)) u_thr (
    .cfg(cfg), .hv_mode(hv_mode), .thr_mv(thr_mv), .rel_mv(rel_mv)
  );

  pfw_cmp #(.MV_W(MV_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .active(active), .take(smp_valid && smp_ready),
    .smp_mv(smp_mv), .thr_mv(thr_mv), .rel_mv(rel_mv),
    .low_q(low_q), .fire(fire)
  );
endmodule

// File: rtl/pfw_monitor_chk.sv
module pfw_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hfclk_run,
  input logic       sys_off,
  input logic       smp_ready,
  input logic       nvm_wr_block,
  input logic       warn_evt,
  input logic       warn_irq,
  input logic       reg_we,
  input logic [1:0] reg_sel,
  input logic [11:0] reg_wdata
);
  AST_INACTIVE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!hfclk_run || sys_off) |-> !smp_ready); // R9
  AST_INACTIVE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!hfclk_run || sys_off) |=> !nvm_wr_block); // R9
  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |-> warn_evt); // R10
  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_evt && !(reg_we && reg_sel == 2'd1 && !reg_wdata[0])) |=> warn_evt); // R10
  AST_BLOCK_RAISES_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nvm_wr_block) |-> warn_evt); // R4
  AST_BLOCK_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_wr_block && $past(nvm_wr_block)) |-> $past(smp_ready)); // R8
endmodule

bind pfw_monitor pfw_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hfclk_run(hfclk_run), .sys_off(sys_off),
  .smp_ready(smp_ready), .nvm_wr_block(nvm_wr_block), .warn_evt(warn_evt),
  .warn_irq(warn_irq), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata)
);

// File: tb/sim_pfw_monitor.sv
module sim_pfw_monitor;
  localparam int MV_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [11:0] reg_wdata = '0;
  logic hv_mode = 1'b0, hfclk_run = 1'b1, sys_off = 1'b0;
  logic smp_valid = 1'b0;
  logic [MV_W-1:0] smp_mv = '0;
  logic smp_ready, warn_evt, warn_irq, nvm_wr_block;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int        at;
    string     tag;
    logic [3:0] exp; // {ready, block, irq, evt}
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pfw_monitor #(.MV_W(MV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .hv_mode(hv_mode), .hfclk_run(hfclk_run),
    .sys_off(sys_off), .smp_valid(smp_valid), .smp_mv(smp_mv),
    .smp_ready(smp_ready), .warn_evt(warn_evt), .warn_irq(warn_irq),
    .nvm_wr_block(nvm_wr_block)
  );

  // monitor: pop and compare expected items in their cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      logic [3:0] got;
      it  = sb.pop_front();
      got = {smp_ready, nvm_wr_block, warn_irq, warn_evt};
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: got rdy/blk/irq/evt=%b expected %b", it.tag, got, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [11:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic smp(input int mv);
    smp_valid = 1'b1; smp_mv = MV_W'(mv);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_o(input string tag, input logic [3:0] e);
    item_t it;
    it.at = cyc + 1; it.tag = tag; it.exp = e;
    sb.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    expect_o("R1 reset state", 4'b0000);
    smp(3000);
    expect_o("R1 reading ignored while disabled", 4'b0000);
    wr(2'd0, 12'd21);                         // enable, normal code 10 = 2300 mV
    expect_o("R2 enable without reading", 4'b1000);
    wr(2'd2, 12'd1);
    expect_o("R10 interrupt enable alone", 4'b1000);
    smp(2400);
    expect_o("R4 above threshold", 4'b1000);
    smp(2300);
    expect_o("R4 equal to threshold", 4'b1000);
    smp(2299);
    expect_o("R4 falling crossing", 4'b1111);
    expect_o("R8 block while below", 4'b1111);
    smp(2350);
    expect_o("R7 at threshold plus hysteresis", 4'b1111);
    smp(2351);
    expect_o("R7 released above margin", 4'b1011);
    wr(2'd1, 12'd1);
    expect_o("R10 write one ignored", 4'b1011);
    wr(2'd1, 12'd0);
    expect_o("R10 write zero clears", 4'b1000);
    wr(2'd0, 12'd31);                         // code 15 = 2800 mV
    expect_o("R6 threshold raised", 4'b1111);
    wr(2'd1, 12'd0);
    expect_o("R10 clear while blocked", 4'b1100);
    wr(2'd0, 12'd5);                          // reserved code 2 = 1700 mV
    expect_o("R2 reserved code releases", 4'b1000);
    smp(1700);
    expect_o("R2 reserved code equal", 4'b1000);
    smp(1699);
    expect_o("R2 reserved code below", 4'b1111);
    wr(2'd1, 12'd0);
    expect_o("R10 clear", 4'b1100);
    hv_mode = 1'b1;
    wr(2'd0, 12'd777);                        // hv code 3 = 3000, normal 1700
    expect_o("R3 high mode keeps below", 4'b1100);
    smp(3100);
    expect_o("R3 high mode release", 4'b1000);
    smp(2999);
    expect_o("R3 high field used", 4'b1111);
    wr(2'd1, 12'd0);
    expect_o("R10 clear again", 4'b1100);
    wr(2'd0, 12'd776);
    expect_o("R5 disabled", 4'b0000);
    wr(2'd0, 12'd777);
    expect_o("R5 enabled while low", 4'b1111);
    wr(2'd1, 12'd0);
    expect_o("R10 clear before clock stop", 4'b1100);
    hfclk_run = 1'b0;
    tick();
    expect_o("R9 clock stopped", 4'b0000);
    smp(1000);
    expect_o("R9 no event while inactive", 4'b0000);
    hfclk_run = 1'b1;
    tick();
    expect_o("R9 resumed with stored reading", 4'b1111);
    wr(2'd1, 12'd0);
    expect_o("R10 clear before sleep", 4'b1100);
    sys_off = 1'b1;
    tick();
    expect_o("R9 deep sleep", 4'b0000);
    sys_off = 1'b0;
    tick();
    expect_o("R9 woken", 4'b1111);
    wr(2'd2, 12'd0);
    expect_o("R10 irq masked", 4'b1101);
    smp(3100);
    expect_o("R10 flag sticky after recovery", 4'b1001);
    repeat (3) tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule